// File: doc/BRIEF.md
# I2C Master Status Flag Unit

This block keeps the event and status flags of a single-master I2C controller and runs the sequences that set and clear them. The bus engine tells it about bus events with one-cycle pulses: a start condition was generated, an address byte went out, a data byte finished in a given direction, an acknowledge failed, an error occurred, or a stop condition was generated. The CPU side reports its register accesses as one-cycle strobes: a status read, an error-register read, a data read and a data write.

From these inputs the block builds the read-only status byte, a level interrupt request and a request to hold the bus clock low. Start, address and byte-done flags clear only through a two-step sequence. The first step is a status read while the flag is set. The second step is the matching data-register access. Each flag remembers the first step in its own armed bit, so a stale status read cannot clear an event that arrived later.

Top module: `i2cm_status_flags`

## Requirements
- R1: After reset the status byte reads 0x00. Bits 6, 4 and 2 always read 0.
- R2: A start-generated pulse sets bit 0 (start done) and bit 7 (event), visible the cycle after the pulse.
- R3: Bit 0 clears only when a status read while it is set is followed by a data write. A data write with no status read before it leaves bit 0 set.
- R4: A byte-done pulse sets bit 3 (transfer done) and bit 7. Bit 5 reads 1 for a transmitted byte and 0 for a received one. The clock-hold output equals bit 3.
- R5: Bit 3 clears after a status read followed by a data write (transmitted byte) or a data read (received byte). The other data access does not clear it. Bit 5 drops together with bit 3.
- R6: An armed clear step is cancelled by any other register access, or by a new setting event for that flag. After that, the completing access leaves the flag set.
- R7: An address-sent pulse sets bit 7 only. That event clears after a status read followed by a data write.
- R8: An acknowledge-failure or error pulse sets bit 7. An error-register read clears it, and data accesses do not.
- R9: A start request sets bit 1 (master). A stop-generated pulse clears it.
- R10: While the enable input is low, the status byte reads 0x00 and event pulses are ignored.
- R11: The interrupt output equals the interrupt-enable input AND bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Interface enable; low clears all flags |
| irq_en_i | input | 1 | Interrupt enable |
| start_req_i | input | 1 | Software wrote a start request |
| start_gen_i | input | 1 | Start condition generated |
| addr_sent_i | input | 1 | Address byte completed |
| byte_done_i | input | 1 | Data byte completed, acknowledge slot included |
| byte_tx_i | input | 1 | Direction of the completed byte, 1 = transmitted |
| ack_fail_i | input | 1 | Acknowledge missing after a transmitted byte |
| bus_err_i | input | 1 | Other error event |
| stop_gen_i | input | 1 | Stop condition generated |
| rd_status_i | input | 1 | CPU read of the status byte |
| rd_error_i | input | 1 | CPU read of the error register |
| rd_data_i | input | 1 | CPU read of the data register |
| wr_data_i | input | 1 | CPU write of the data register |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request level |
| hold_scl_o | output | 1 | Request to hold the bus clock low |

## Verification
Every flag is one register stage from its input. A pulse or access applied in one cycle therefore shows on the status byte and the clock-hold output exactly one cycle later. The interrupt is a combinational AND of its enable with bit 7, so it follows in that same cycle, or at once when only the enable changes. The bench drives each stimulus on a falling edge and compares all three outputs on the next falling edge, one full cycle on. The armed-step cases are laid out as separate cycles, so cancellation by a later access or a new event can be seen at the ports.

// File: rtl/i2cm_flag_pkg.sv
package i2cm_flag_pkg;
  localparam int STAT_W    = 8;
  localparam int POS_START = 0;
  localparam int POS_MST   = 1;
  localparam int POS_XFER  = 3;
  localparam int POS_DIR   = 5;
  localparam int POS_EVT   = 7;
  // sticky cells cleared by a two-step access sequence
  localparam int NCELL     = 3;
  localparam int CELL_START = 0;
  localparam int CELL_ADDR  = 1;
  localparam int CELL_XFER  = 2;
endpackage

// File: rtl/i2cm_seq_flag.sv
module i2cm_seq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic set_i,
  input  logic arm_rd_i,
  input  logic clr_acc_i,
  input  logic other_acc_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (!enable_i) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (set_i) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (arm_q && clr_acc_i) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (arm_rd_i && flag_q) begin
      arm_d  = 1'b1;
    end else if (other_acc_i) begin
      arm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R3/R5: a flag only falls after a completed sequence or disable
  a_r3_fall_needs_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(!enable_i) || $past(arm_q && clr_acc_i)));
  // R6: a new event sets the flag and cancels any armed step
  a_r6_set_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && set_i) |=> (flag_q && !arm_q));
  // R10: disable wipes flag and arm
  a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!flag_q && !arm_q));
endmodule

// File: rtl/i2cm_ctl_bits.sv
module i2cm_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic start_req_i,
  input  logic stop_gen_i,
  input  logic byte_done_i,
  input  logic byte_tx_i,
  input  logic ack_fail_i,
  input  logic bus_err_i,
  input  logic rd_error_i,
  output logic mst_o,
  output logic dir_o,
  output logic err_o
);
  logic mst_q, mst_d;
  logic dir_q, dir_d;
  logic err_q, err_d;

  always_comb begin
    mst_d = mst_q;
    dir_d = dir_q;
    err_d = err_q;
    if (!enable_i) begin
      mst_d = 1'b0;
      dir_d = 1'b0;
      err_d = 1'b0;
    end else begin
      if (start_req_i)     mst_d = 1'b1;
      else if (stop_gen_i) mst_d = 1'b0;
      if (byte_done_i)     dir_d = byte_tx_i;
      if (ack_fail_i || bus_err_i) err_d = 1'b1;
      else if (rd_error_i)         err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= 1'b0;
      dir_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      mst_q <= mst_d;
      dir_q <= dir_d;
      err_q <= err_d;
    end
  end

  assign mst_o = mst_q;
  assign dir_o = dir_q;
  assign err_o = err_q;

  // R9: stop without a competing start drops master
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && stop_gen_i && !start_req_i) |=> !mst_q);
  // R8: error read with no new error clears the error event
  a_r8_err_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && rd_error_i && !ack_fail_i && !bus_err_i) |=> !err_q);
endmodule

// File: rtl/i2cm_status_flags.sv
module i2cm_status_flags
  import i2cm_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              irq_en_i,
  input  logic              start_req_i,
  input  logic              start_gen_i,
  input  logic              addr_sent_i,
  input  logic              byte_done_i,
  input  logic              byte_tx_i,
  input  logic              ack_fail_i,
  input  logic              bus_err_i,
  input  logic              stop_gen_i,
  input  logic              rd_status_i,
  input  logic              rd_error_i,
  input  logic              rd_data_i,
  input  logic              wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              hold_scl_o
);
  logic [NCELL-1:0] cell_set, cell_clr, cell_flag;
  logic             mst, dir, err;
  logic             other_acc, evt;

  assign other_acc = rd_error_i | rd_data_i | wr_data_i;

  always_comb begin
    cell_set             = '0;
    cell_clr             = '0;
    cell_set[CELL_START] = start_gen_i;
    cell_set[CELL_ADDR]  = addr_sent_i;
    cell_set[CELL_XFER]  = byte_done_i;
    cell_clr[CELL_START] = wr_data_i;
    cell_clr[CELL_ADDR]  = wr_data_i;
    cell_clr[CELL_XFER]  = dir ? wr_data_i : rd_data_i;
  end

  for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
    i2cm_seq_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (enable_i),
      .set_i      (cell_set[gi]),
      .arm_rd_i   (rd_status_i),
      .clr_acc_i  (cell_clr[gi]),
      .other_acc_i(other_acc),
      .flag_o     (cell_flag[gi])
    );
  end

  i2cm_ctl_bits u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .start_req_i(start_req_i),
    .stop_gen_i (stop_gen_i),
    .byte_done_i(byte_done_i),
    .byte_tx_i  (byte_tx_i),
    .ack_fail_i (ack_fail_i),
    .bus_err_i  (bus_err_i),
    .rd_error_i (rd_error_i),
    .mst_o      (mst),
    .dir_o      (dir),
    .err_o      (err)
  );

  assign evt = |cell_flag | err;

  always_comb begin
    status_o            = '0;
    status_o[POS_EVT]   = evt;
    status_o[POS_DIR]   = dir & cell_flag[CELL_XFER];
    status_o[POS_XFER]  = cell_flag[CELL_XFER];
    status_o[POS_MST]   = mst;
    status_o[POS_START] = cell_flag[CELL_START];
  end

  assign irq_o      = irq_en_i & evt;
  assign hold_scl_o = cell_flag[CELL_XFER];

  // R4: clock hold only rises after a byte-done pulse
  a_r4_hold_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_scl_o) |-> $past(byte_done_i && enable_i));
  // R2: start generation is reflected one cycle later
  a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && start_gen_i) |=> (status_o[POS_START] && status_o[POS_EVT]));
endmodule

// File: tb/i2cm_status_flags_bench.sv
module i2cm_status_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0, irq_en_i = 1'b0;
  logic start_req_i = 1'b0, start_gen_i = 1'b0, addr_sent_i = 1'b0;
  logic byte_done_i = 1'b0, byte_tx_i = 1'b0, ack_fail_i = 1'b0;
  logic bus_err_i = 1'b0, stop_gen_i = 1'b0;
  logic rd_status_i = 1'b0, rd_error_i = 1'b0, rd_data_i = 1'b0, wr_data_i = 1'b0;
  logic [7:0] status_o;
  logic irq_o, hold_scl_o;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  i2cm_status_flags u_i2cm_status_flags (.*);

  localparam logic [3:0] NOP = 0, SREQ = 1, SGEN = 2, ADDR = 3, BTX = 4, BRX = 5,
    AFAIL = 6, ERR = 7, STOP = 8, RSTAT = 9, RERR = 10, RDAT = 11, WDAT = 12;

  // {en, irq_en, op, expected status, expected irq, requirement}
  localparam int NV = 37;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,1'b1,NOP  ,8'h00,1'b0,8'd1 },  // R1
    {1'b1,1'b1,SREQ ,8'h02,1'b0,8'd9 },  // R9
    {1'b1,1'b1,SGEN ,8'h83,1'b1,8'd2 },  // R2
    {1'b1,1'b1,WDAT ,8'h83,1'b1,8'd3 },  // R3 write without read
    {1'b1,1'b1,RSTAT,8'h83,1'b1,8'd3 },
    {1'b1,1'b1,WDAT ,8'h02,1'b0,8'd3 },  // R3 sequence clears
    {1'b1,1'b1,ADDR ,8'h82,1'b1,8'd7 },  // R7
    {1'b1,1'b1,RSTAT,8'h82,1'b1,8'd7 },
    {1'b1,1'b1,WDAT ,8'h02,1'b0,8'd7 },
    {1'b1,1'b1,BTX  ,8'hAA,1'b1,8'd4 },  // R4 transmit
    {1'b1,1'b1,RSTAT,8'hAA,1'b1,8'd5 },
    {1'b1,1'b1,RDAT ,8'hAA,1'b1,8'd5 },  // R5 wrong access
    {1'b1,1'b1,WDAT ,8'hAA,1'b1,8'd6 },  // R6 disarmed
    {1'b1,1'b1,RSTAT,8'hAA,1'b1,8'd5 },
    {1'b1,1'b1,WDAT ,8'h02,1'b0,8'd5 },  // R5 bit5 drops too
    {1'b1,1'b1,BRX  ,8'h8A,1'b1,8'd4 },  // R4 receive
    {1'b1,1'b1,RSTAT,8'h8A,1'b1,8'd5 },
    {1'b1,1'b1,RDAT ,8'h02,1'b0,8'd5 },
    {1'b1,1'b1,BRX  ,8'h8A,1'b1,8'd4 },
    {1'b1,1'b1,RSTAT,8'h8A,1'b1,8'd6 },
    {1'b1,1'b1,BRX  ,8'h8A,1'b1,8'd6 },  // R6 new event disarms
    {1'b1,1'b1,RDAT ,8'h8A,1'b1,8'd6 },
    {1'b1,1'b1,RSTAT,8'h8A,1'b1,8'd5 },
    {1'b1,1'b1,RDAT ,8'h02,1'b0,8'd5 },
    {1'b1,1'b1,AFAIL,8'h82,1'b1,8'd8 },  // R8
    {1'b1,1'b1,RSTAT,8'h82,1'b1,8'd8 },
    {1'b1,1'b1,WDAT ,8'h82,1'b1,8'd8 },
    {1'b1,1'b1,RERR ,8'h02,1'b0,8'd8 },
    {1'b1,1'b0,ERR  ,8'h82,1'b0,8'd11},  // R11 masked
    {1'b1,1'b0,RERR ,8'h02,1'b0,8'd8 },
    {1'b1,1'b1,STOP ,8'h00,1'b0,8'd9 },
    {1'b1,1'b1,SREQ ,8'h02,1'b0,8'd9 },
    {1'b1,1'b1,SGEN ,8'h83,1'b1,8'd2 },
    {1'b1,1'b1,BTX  ,8'hAB,1'b1,8'd4 },
    {1'b0,1'b1,NOP  ,8'h00,1'b0,8'd10},  // R10
    {1'b0,1'b1,SGEN ,8'h00,1'b0,8'd10},
    {1'b1,1'b1,NOP  ,8'h00,1'b0,8'd10}
  };

  task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic ie, input logic [3:0] op);
    @(negedge clk);
    enable_i = en; irq_en_i = ie;
    start_req_i = (op == SREQ); start_gen_i = (op == SGEN); addr_sent_i = (op == ADDR);
    byte_done_i = (op == BTX) || (op == BRX); byte_tx_i = (op == BTX);
    ack_fail_i = (op == AFAIL); bus_err_i = (op == ERR); stop_gen_i = (op == STOP);
    rd_status_i = (op == RSTAT); rd_error_i = (op == RERR);
    rd_data_i = (op == RDAT); wr_data_i = (op == WDAT);
    @(negedge clk);
    {start_req_i, start_gen_i, addr_sent_i, byte_done_i, byte_tx_i, ack_fail_i} = '0;
    {bus_err_i, stop_gen_i, rd_status_i, rd_error_i, rd_data_i, wr_data_i} = '0;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset status", 1, status_o, 8'h00);  // R1
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][22], VEC[i][21], VEC[i][20:17]);
      check($sformatf("vec %0d status", i), int'(VEC[i][7:0]), status_o, VEC[i][16:9]);
      check($sformatf("vec %0d irq", i), 11, {7'b0, irq_o}, {7'b0, VEC[i][8]});  // R11
      check($sformatf("vec %0d hold", i), 4, {7'b0, hold_scl_o}, {7'b0, VEC[i][12]});  // R4
    end
    // R11: irq follows enable combinationally
    apply(1'b1, 1'b1, ADDR);
    irq_en_i = 1'b0; #1;
    check("irq masked", 11, {7'b0, irq_o}, 8'h00);
    irq_en_i = 1'b1; #1;
    check("irq unmasked", 11, {7'b0, irq_o}, 8'h01);
    // R6: error-register read between the two steps cancels the arm
    apply(1'b1, 1'b1, RSTAT);
    apply(1'b1, 1'b1, RERR);
    apply(1'b1, 1'b1, WDAT);
    check("rerr disarms", 6, status_o, 8'h80);
    // R1: asynchronous reset mid-run
    apply(1'b1, 1'b1, SREQ);
    @(negedge clk); rst_n = 1'b0; #1;
    check("reset mid-run", 1, status_o, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule